// File: doc/BRIEF.md
# Registered Tri-Port Bus Exchanger

This block sits between one processor-side data port (A) and two memory-bank ports, an even bank (B1) and an odd bank (B2), and moves words between them through four clocked directional registers. Two registers carry data from A toward B1 and B2. Two more carry data from B1 and B2 back toward A. Each register has its own active-low load enable. Every control input is sampled on the single shared clock: the four load enables, the A-side source choice and the two output enables. A change of direction therefore always lands on a clock edge.

Each bidirectional port is split into an input word, an external-drive flag (high while another agent drives the bus), an output word and an output-enable flag. Every port has a bus-hold keeper. When neither the block nor an outside agent drives a bus, the keeper supplies the last driven level, and any register that loads from that bus captures the held level. When the block drives a port itself, the bus carries the block's own output word, and the external word is ignored.

The A-side source selector is a two-state register, with states `SRC_EVEN` (B1-to-A register drives A) and `SRC_ODD` (B2-to-A register drives A). The transition `SRC_ODD -> SRC_EVEN` is taken on an edge with `pick_b1` high. The transition `SRC_EVEN -> SRC_ODD` is taken on an edge with `pick_b1` low. Reset enters `SRC_ODD`.

Top module: `bus_exchanger`

## Requirements
- R1: With `rst` high at a rising edge, all four data registers, all three keepers, `a_oe`, `b1_oe` and `b2_oe` clear to zero after that edge, so `a_out`, `b1_out` and `b2_out` read 0 and no port drives.
- R2: When `ld_a_b1_n` is low at a rising edge, the A-to-B1 register takes the resolved A-bus value, and `b1_out` shows it from that edge on.
- R3: A data register whose load enable is high at an edge keeps its previous contents, and the port it feeds keeps showing that value.
- R4: With both `ld_a_b1_n` and `ld_a_b2_n` low on the same edge, the A-bus value lands in both A-to-B registers, and both `b1_out` and `b2_out` show it.
- R5: `ld_b1_a_n` and `ld_b2_a_n` load the B1-to-A and B2-to-A registers from the resolved B1 and B2 buses. `a_out` shows the B1-to-A register in state `SRC_EVEN` and the B2-to-A register in state `SRC_ODD`.
- R6: `pick_b1` acts only at a rising edge. A change between edges leaves `a_out` unchanged until the next edge.
- R7: `a_oe` becomes the inverse of `a_en_n` as sampled at each rising edge, and it does not follow `a_en_n` between edges.
- R8: One enable, `b_en_n`, drives both `b1_oe` and `b2_oe`. After each edge both flags equal the inverse of the sampled `b_en_n`.
- R9: A bus that nobody drives (its own output enable low and its external-drive flag low) presents the last value that was driven on it. A register loading from that bus captures that held value, and the external word is ignored.
- R10: While a port's own output enable is high, the bus carries the block's output word. A register loading from that bus captures the output word, and the port's external word is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Word driven onto port A from outside |
| a_drv | input | 1 | High while an outside agent drives port A |
| a_out | output | 12 | Word the block presents on port A |
| a_oe | output | 1 | Port A driven by the block |
| b1_in | input | 12 | Word driven onto port B1 from outside |
| b1_drv | input | 1 | High while an outside agent drives port B1 |
| b1_out | output | 12 | Word the block presents on port B1 |
| b1_oe | output | 1 | Port B1 driven by the block |
| b2_in | input | 12 | Word driven onto port B2 from outside |
| b2_drv | input | 1 | High while an outside agent drives port B2 |
| b2_out | output | 12 | Word the block presents on port B2 |
| b2_oe | output | 1 | Port B2 driven by the block |
| ld_a_b1_n | input | 1 | Load enable, A-to-B1 register, active low |
| ld_a_b2_n | input | 1 | Load enable, A-to-B2 register, active low |
| ld_b1_a_n | input | 1 | Load enable, B1-to-A register, active low |
| ld_b2_a_n | input | 1 | Load enable, B2-to-A register, active low |
| pick_b1 | input | 1 | A-side source choice: 1 selects B1-to-A, 0 selects B2-to-A |
| a_en_n | input | 1 | Port A output enable, active low, registered |
| b_en_n | input | 1 | Shared B-port output enable, active low, registered |

## Verification
All state sits in registers, so a wrong value shows up at the ports one edge after the fault. A corrupted data register appears directly on its port word. A wrong selector state swaps B1 and B2 data on `a_out`. A keeper that wrongly updates on an undriven cycle stays hidden until a register loads from the floating bus. The word that register later shows is then stale, which can surface many cycles after the fault. For this reason the bench loads from floating buses on purpose and compares every port on every cycle with an independent cycle model.

// File: rtl/bx_pkg.sv
package bx_pkg;
    // A-side source selector states; the encoding matches the pick_b1 level
    typedef enum logic {
        SRC_ODD  = 1'b0,
        SRC_EVEN = 1'b1
    } a_src_e;
endpackage

// File: rtl/bx_dreg.sv
module bx_dreg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (!ld_n) q <= d;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        !ld_n |=> q == $past(d));
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable(q));
endmodule

// File: rtl/bx_keeper.sv
module bx_keeper #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         own_oe,
    input  logic [W-1:0] own_val,
    input  logic         ext_drv,
    input  logic [W-1:0] ext_val,
    output logic [W-1:0] bus
);
    logic [W-1:0] held_q;
    logic         driven;

    assign driven = own_oe || ext_drv;

    always_comb begin
        if (own_oe)       bus = own_val;
        else if (ext_drv) bus = ext_val;
        else              bus = held_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         held_q <= '0;
        else if (driven) held_q <= bus;
    end

    assert_float_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !driven |=> $stable(held_q));
    assert_own_wins_R10: assert property (@(posedge clk) disable iff (rst)
        own_oe |=> held_q == $past(own_val));
endmodule

// File: rtl/bx_ctrl.sv
module bx_ctrl #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pick_b1,
    input  logic         a_en_n,
    input  logic         b_en_n,
    input  logic [W-1:0] even_q,
    input  logic [W-1:0] odd_q,
    output logic [W-1:0] a_word,
    output logic         a_oe,
    output logic         b_oe
);
    import bx_pkg::*;

    a_src_e src_q, src_d;
    logic   a_oe_q, b_oe_q;

    always_comb begin
        src_d = pick_b1 ? SRC_EVEN : SRC_ODD;
    end

    // state register for selector and enables
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_ODD;
            a_oe_q <= 1'b0;
            b_oe_q <= 1'b0;
        end else begin
            src_q  <= src_d;
            a_oe_q <= !a_en_n;
            b_oe_q <= !b_en_n;
        end
    end

    // output process
    always_comb begin
        unique case (src_q)
            SRC_EVEN: a_word = even_q;
            SRC_ODD:  a_word = odd_q;
            default:  a_word = odd_q;
        endcase
        a_oe = a_oe_q;
        b_oe = b_oe_q;
    end

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> (!a_oe && !b_oe && src_q == SRC_ODD));
    assert_sel_edge_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> src_q == ($past(pick_b1) ? SRC_EVEN : SRC_ODD));
    assert_a_enable_R7: assert property (@(posedge clk) disable iff (rst)
        a_en_n |=> !a_oe);
    assert_b_enable_R8: assert property (@(posedge clk) disable iff (rst)
        !b_en_n |=> b_oe);
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         a_drv,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b1_in,
    input  logic         b1_drv,
    output logic [W-1:0] b1_out,
    output logic         b1_oe,
    input  logic [W-1:0] b2_in,
    input  logic         b2_drv,
    output logic [W-1:0] b2_out,
    output logic         b2_oe,
    input  logic         ld_a_b1_n,
    input  logic         ld_a_b2_n,
    input  logic         ld_b1_a_n,
    input  logic         ld_b2_a_n,
    input  logic         pick_b1,
    input  logic         a_en_n,
    input  logic         b_en_n
);
    localparam int NB = 2;

    logic [W-1:0] bus_a;
    logic [W-1:0] to_b   [NB];
    logic [W-1:0] from_b [NB];
    logic [W-1:0] bus_b  [NB];
    logic [W-1:0] b_ext  [NB];
    logic         b_drv  [NB];
    logic         ld_tob_n [NB];
    logic         ld_frb_n [NB];
    logic         b_oe;
    logic [W-1:0] a_word;

    assign b_ext[0]    = b1_in;
    assign b_ext[1]    = b2_in;
    assign b_drv[0]    = b1_drv;
    assign b_drv[1]    = b2_drv;
    assign ld_tob_n[0] = ld_a_b1_n;
    assign ld_tob_n[1] = ld_a_b2_n;
    assign ld_frb_n[0] = ld_b1_a_n;
    assign ld_frb_n[1] = ld_b2_a_n;

    bx_keeper #(.W(W)) u_keep_a (
        .clk(clk), .rst(rst), .own_oe(a_oe), .own_val(a_word),
        .ext_drv(a_drv), .ext_val(a_in), .bus(bus_a)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        bx_dreg #(.W(W)) u_to_b (
            .clk(clk), .rst(rst), .ld_n(ld_tob_n[i]), .d(bus_a), .q(to_b[i])
        );
        bx_keeper #(.W(W)) u_keep_b (
            .clk(clk), .rst(rst), .own_oe(b_oe), .own_val(to_b[i]),
            .ext_drv(b_drv[i]), .ext_val(b_ext[i]), .bus(bus_b[i])
        );
        bx_dreg #(.W(W)) u_from_b (
            .clk(clk), .rst(rst), .ld_n(ld_frb_n[i]), .d(bus_b[i]), .q(from_b[i])
        );
    end

    bx_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .pick_b1(pick_b1), .a_en_n(a_en_n),
        .b_en_n(b_en_n), .even_q(from_b[0]), .odd_q(from_b[1]),
        .a_word(a_word), .a_oe(a_oe), .b_oe(b_oe)
    );

    assign a_out  = a_word;
    assign b1_out = to_b[0];
    assign b2_out = to_b[1];
    assign b1_oe  = b_oe;
    assign b2_oe  = b_oe;

    assert_dual_load_R4: assert property (@(posedge clk) disable iff (rst)
        (!ld_a_b1_n && !ld_a_b2_n) |=> b1_out == b2_out);
    assert_a_source_R5: assert property (@(posedge clk) disable iff (rst)
        (pick_b1 && ld_b1_a_n) |=> a_out == $past(from_b[0]));
endmodule

// File: tb/sim_bus_exchanger.sv
module sim_bus_exchanger;
    localparam int W  = 12;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic a_drv, b1_drv, b2_drv;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic a_oe, b1_oe, b2_oe;
    logic ld_a1, ld_a2, ld_1a, ld_2a, pick, aen, ben;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bus_exchanger #(.W(W)) u0 (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_drv(b1_drv), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_drv(b2_drv), .b2_out(b2_out), .b2_oe(b2_oe),
        .ld_a_b1_n(ld_a1), .ld_a_b2_n(ld_a2), .ld_b1_a_n(ld_1a), .ld_b2_a_n(ld_2a),
        .pick_b1(pick), .a_en_n(aen), .b_en_n(ben)
    );

    // fields: ld{a1,a2,1a,2a} | pick | aen | ben | drv{a,b1,b2} | a_in | b1_in | b2_in
    localparam logic [45:0] VEC [NV] = '{
        {4'b0011, 1'b0, 1'b1, 1'b0, 3'b100, 12'hA5A, 12'h000, 12'h000},
        {4'b1111, 1'b0, 1'b1, 1'b1, 3'b000, 12'hFFF, 12'h000, 12'h000},
        {4'b1100, 1'b1, 1'b1, 1'b1, 3'b011, 12'h000, 12'h3C3, 12'h7E7},
        {4'b1111, 1'b1, 1'b0, 1'b1, 3'b000, 12'h000, 12'h000, 12'h000},
        {4'b1111, 1'b0, 1'b0, 1'b1, 3'b000, 12'h000, 12'h000, 12'h000},
        {4'b1010, 1'b0, 1'b0, 1'b1, 3'b000, 12'h123, 12'h456, 12'h789},
        {4'b0111, 1'b0, 1'b0, 1'b0, 3'b100, 12'h001, 12'h000, 12'h000},
        {4'b1101, 1'b1, 1'b1, 1'b0, 3'b010, 12'h000, 12'h888, 12'h000},
        {4'b1100, 1'b1, 1'b1, 1'b1, 3'b000, 12'h000, 12'h000, 12'h000},
        {4'b0011, 1'b1, 1'b1, 1'b1, 3'b000, 12'hBAD, 12'h000, 12'h000},
        {4'b1111, 1'b0, 1'b0, 1'b1, 3'b001, 12'h000, 12'h000, 12'h055},
        {4'b1011, 1'b1, 1'b0, 1'b0, 3'b111, 12'hC0C, 12'h0D0, 12'h0E0}
    };

    // independent cycle model
    logic [W-1:0] m_a1, m_a2, m_1a, m_2a, m_ka, m_k1, m_k2;
    logic m_sel, m_aoe, m_boe;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_a1 = '0; m_a2 = '0; m_1a = '0; m_2a = '0;
        m_ka = '0; m_k1 = '0; m_k2 = '0;
        m_sel = 1'b0; m_aoe = 1'b0; m_boe = 1'b0;
    endtask

    task automatic model_step();
        logic [W-1:0] ma_out, ba, bb1, bb2;
        ma_out = m_sel ? m_1a : m_2a;
        ba  = m_aoe ? ma_out : (a_drv  ? a_in  : m_ka);
        bb1 = m_boe ? m_a1   : (b1_drv ? b1_in : m_k1);
        bb2 = m_boe ? m_a2   : (b2_drv ? b2_in : m_k2);
        if (m_aoe || a_drv)  m_ka = ba;
        if (m_boe || b1_drv) m_k1 = bb1;
        if (m_boe || b2_drv) m_k2 = bb2;
        if (!ld_a1) m_a1 = ba;
        if (!ld_a2) m_a2 = ba;
        if (!ld_1a) m_1a = bb1;
        if (!ld_2a) m_2a = bb2;
        m_sel = pick; m_aoe = !aen; m_boe = !ben;
    endtask

    task automatic compare_all();
        chk("R5 a_out", a_out, m_sel ? m_1a : m_2a);
        chk("R7 a_oe", a_oe, m_aoe);
        chk("R2 b1_out", b1_out, m_a1);
        chk("R4 b2_out", b2_out, m_a2);
        chk("R8 b1_oe", b1_oe, m_boe);
        chk("R8 b2_oe", b2_oe, m_boe);
    endtask

    task automatic apply(input logic [45:0] v);
        {ld_a1, ld_a2, ld_1a, ld_2a} = v[45:42];
        pick = v[41]; aen = v[40]; ben = v[39];
        {a_drv, b1_drv, b2_drv} = v[38:36];
        a_in = v[35:24]; b1_in = v[23:12]; b2_in = v[11:0];
    endtask

    // drive at negedge, clock, return at next negedge
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        apply({4'b1111, 1'b0, 1'b1, 1'b1, 3'b000, 12'h0, 12'h0, 12'h0});
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 a_oe", a_oe, 0);
        chk("R1 b1_oe", b1_oe, 0);
        chk("R1 b2_oe", b2_oe, 0);
        chk("R1 a_out", a_out, 0);
        chk("R1 b1_out", b1_out, 0);
        chk("R1 b2_out", b2_out, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            tick();
            compare_all();
        end

        // random traffic
        for (int i = 0; i < 400; i++) begin
            apply({$urandom, $urandom});
            tick();
            compare_all();
        end

        // directed corner cases
        do_reset();
        apply({4'b0111, 1'b0, 1'b1, 1'b0, 3'b100, 12'h5A5, 12'h0, 12'h0});
        tick();
        chk("R2 b1 load", b1_out, 12'h5A5);
        chk("R8 b1_oe on", b1_oe, 1);
        chk("R8 b2_oe on", b2_oe, 1);

        apply({4'b1111, 1'b0, 1'b1, 1'b0, 3'b100, 12'h111, 12'h0, 12'h0});
        tick();
        chk("R3 b1 held", b1_out, 12'h5A5);

        apply({4'b0011, 1'b0, 1'b1, 1'b0, 3'b100, 12'h0F0, 12'h0, 12'h0});
        tick();
        chk("R4 b1 dual", b1_out, 12'h0F0);
        chk("R4 b2 dual", b2_out, 12'h0F0);

        apply({4'b0111, 1'b0, 1'b1, 1'b1, 3'b000, 12'hFFF, 12'h0, 12'h0});
        tick();
        chk("R9 keeper level", b1_out, 12'h0F0);

        apply({4'b1111, 1'b0, 1'b1, 1'b1, 3'b000, 12'h0, 12'h0, 12'h0});
        tick();
        apply({4'b1100, 1'b1, 1'b0, 1'b1, 3'b011, 12'h0, 12'h123, 12'h456});
        tick();
        chk("R5 even source", a_out, 12'h123);
        chk("R7 a_oe on", a_oe, 1);

        apply({4'b1111, 1'b0, 1'b1, 1'b1, 3'b000, 12'h0, 12'h0, 12'h0});
        #2;
        chk("R6 before edge", a_out, 12'h123);
        chk("R7 before edge", a_oe, 1);
        tick();
        chk("R6 after edge", a_out, 12'h456);
        chk("R7 a_oe off", a_oe, 0);

        apply({4'b1111, 1'b0, 1'b0, 1'b1, 3'b000, 12'h0, 12'h0, 12'h0});
        tick();
        apply({4'b1011, 1'b0, 1'b0, 1'b1, 3'b100, 12'h000, 12'h0, 12'h0});
        tick();
        chk("R10 own drive", b2_out, 12'h456);

        idle();
        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule